// File: doc/BRIEF.md
# Serial Management Slave for a Physical-Layer Device

This block is the device side of the two-wire management bus that a station manager uses to read and write the control and status registers of a physical-layer transceiver. It runs directly on the management clock and samples the data line on every rising edge. It hunts for a run of ones, then decodes a start pattern, an opcode, a device address and a register address. If the frame is addressed to the device's strapped address, it performs the access on an external 32 x 16 register file.

For a read, the block fetches the addressed word. It leaves the line released for the first turnaround bit and drives zero on the second. It then shifts out the 16 data bits, most significant first, and releases the line for the idle bit. For a write, it gathers 16 bits and issues a single write strobe after the last one. The line is driven through a separate output-enable, so the pad and its pull-up sit outside the block.

The external configuration logic owns the register that allows the preamble to be skipped. The block sees that register bit as one input.

Top module: `mdio_slave`

## Requirements
- R1: With skipping disabled, a frame is recognised only after at least 32 consecutive ones sampled on the data line. A shorter run of ones followed by the start pattern causes no drive and no write strobe.
- R2: With `pre_sup_en` high, a frame is accepted when its start pattern follows directly after an idle one, with no preamble.
- R3: A frame is start bits 0,1, then opcode 1,0 (read) or 0,1 (write), then a 5-bit device address and a 5-bit register address, both most significant bit first. In an addressed read, `mdio_oe` stays low for the first turnaround bit and is high with `mdio_o` low for the second.
- R4: In an addressed read, the 16 bits of the addressed word appear on the line most significant first, one per rising edge after the turnaround. The line is released for the idle bit that follows.
- R5: An addressed write raises `rf_we` for exactly one clock, starting at the edge that samples the 16th data bit, with `rf_addr` and `rf_wdata` holding the register address and the received word. No strobe occurs earlier in the frame.
- R6: A frame whose device address differs from `phy_addr` never drives the line and never strobes a write.
- R7: A start pattern other than 0,1 or an opcode other than 1,0 or 0,1 abandons the frame. Its remaining bits cause no drive and no write.
- R8: After reset, `mdio_oe` and `rf_we` are low.
- R9: With skipping disabled, a frame sent immediately after the idle bit of a previous frame, without a new preamble, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mdc | input | 1 | Management clock from the station manager |
| rst_n | input | 1 | Asynchronous active-low reset |
| phy_addr | input | 5 | Strapped device address |
| pre_sup_en | input | 1 | Allows frames without preamble |
| mdio_i | input | 1 | Resolved level of the data line |
| mdio_o | output | 1 | Value to drive on the data line |
| mdio_oe | output | 1 | Drive enable for the data line |
| rf_addr | output | 5 | Register file address |
| rf_rdata | input | 16 | Register file read data for `rf_addr` |
| rf_we | output | 1 | Register file write strobe |
| rf_wdata | output | 16 | Register file write data |

## Verification
The bench builds the block with its default parameters: a 32-bit preamble threshold, 16-bit data and 5-bit addresses. These are the widths that set where the turnaround and the idle bit fall. The one-bit-short case can therefore be driven exactly at 31 ones, and each read is checked bit by bit against the turnaround position. The bench models the line with a pull-up, so released bits read as one. It pairs writes with later reads, which brings the effect of ignored and aborted frames out through the register file.

// File: rtl/mdio_slave.sv
module mdio_slave #(
  parameter int PRE_LEN = 32,
  parameter int DATA_W  = 16,
  parameter int ADDR_W  = 5
) (
  input  logic              mdc,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] phy_addr,
  input  logic              pre_sup_en,
  input  logic              mdio_i,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic [ADDR_W-1:0] rf_addr,
  input  logic [DATA_W-1:0] rf_rdata,
  output logic              rf_we,
  output logic [DATA_W-1:0] rf_wdata
);

  localparam int CMAX = (PRE_LEN > DATA_W) ? PRE_LEN : DATA_W;
  localparam int CW   = $clog2(CMAX + 1);
  localparam int AW2  = 2 * ADDR_W;

  typedef enum logic [2:0] {S_PRE, S_ST, S_OP, S_ADR, S_TA, S_DAT} st_t;

  st_t               st;
  logic [CW-1:0]     cnt;
  logic              rd, hit, oe_q, do_q, we_q;
  logic [DATA_W-1:0] sh;
  logic [ADDR_W-1:0] reg_q;

  wire [AW2-1:0] adr_next = {sh[AW2-2:0], mdio_i};
  wire           drive    = rd && hit;

  assign mdio_o   = do_q;
  assign mdio_oe  = oe_q;
  assign rf_addr  = reg_q;
  assign rf_we    = we_q;
  assign rf_wdata = sh;

  always_ff @(posedge mdc or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_PRE;
      cnt   <= '0;
      rd    <= 1'b0;
      hit   <= 1'b0;
      oe_q  <= 1'b0;
      do_q  <= 1'b0;
      we_q  <= 1'b0;
      sh    <= '0;
      reg_q <= '0;
    end else begin
      we_q <= 1'b0;
      case (st)
        S_PRE: begin
          if (mdio_i) begin
            if (cnt != CW'(PRE_LEN)) cnt <= cnt + 1'b1;
          end else begin
            if (cnt == CW'(PRE_LEN) || pre_sup_en) st <= S_ST;
            cnt <= '0;
          end
        end
        S_ST: st <= mdio_i ? S_OP : S_PRE;
        S_OP: begin
          if (cnt == '0) begin
            rd  <= mdio_i;
            cnt <= CW'(1);
          end else begin
            cnt <= '0;
            st  <= (rd != mdio_i) ? S_ADR : S_PRE;
          end
        end
        S_ADR: begin
          sh <= {sh[DATA_W-2:0], mdio_i};
          if (cnt == CW'(AW2 - 1)) begin
            reg_q <= adr_next[ADDR_W-1:0];
            hit   <= adr_next[AW2-1:ADDR_W] == phy_addr;
            cnt   <= '0;
            st    <= S_TA;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_TA: begin
          if (cnt == '0) begin
            cnt <= CW'(1);
            if (drive) begin
              oe_q <= 1'b1;
              do_q <= 1'b0;
              sh   <= rf_rdata;
            end
          end else begin
            cnt <= '0;
            st  <= S_DAT;
            if (drive) begin
              do_q <= sh[DATA_W-1];
              sh   <= {sh[DATA_W-2:0], 1'b0};
            end
          end
        end
        S_DAT: begin
          if (rd) begin
            do_q <= sh[DATA_W-1];
            sh   <= {sh[DATA_W-2:0], 1'b0};
          end else begin
            sh <= {sh[DATA_W-2:0], mdio_i};
          end
          if (cnt == CW'(DATA_W - 1)) begin
            st   <= S_PRE;
            cnt  <= '0;
            oe_q <= 1'b0;
            we_q <= hit && !rd;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= S_PRE;
      endcase
    end
  end

  a_r3_ta_low: assert property (@(posedge mdc) disable iff (!rst_n)
    $rose(mdio_oe) |-> !mdio_o);

  a_r4_release_idle: assert property (@(posedge mdc) disable iff (!rst_n)
    $fell(mdio_oe) |-> st == S_PRE);

  a_r5_we_single: assert property (@(posedge mdc) disable iff (!rst_n)
    rf_we |=> !rf_we);

  a_r5_we_not_in_read: assert property (@(posedge mdc) disable iff (!rst_n)
    !(rf_we && mdio_oe));

  a_r6_drive_needs_match: assert property (@(posedge mdc) disable iff (!rst_n)
    mdio_oe |-> hit && rd);

  a_r7_drive_after_addr: assert property (@(posedge mdc) disable iff (!rst_n)
    mdio_oe |-> (st == S_TA || st == S_DAT));

endmodule

// File: tb/mdio_slave_tb.sv
`timescale 1ns/1ps
module mdio_slave_tb;
  logic        mdc = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  phy_addr = 5'd9;
  logic        pre_sup_en = 1'b0;
  logic        sta_bit = 1'b1;
  logic        mdio_i, mdio_o, mdio_oe, rf_we;
  logic [4:0]  rf_addr;
  logic [15:0] rf_rdata, rf_wdata;
  logic [15:0] mem [32];
  int checks = 0, failures = 0;
  logic obs_oe, obs_o, obs_we;

  always #2.5 mdc = ~mdc;

  assign mdio_i   = mdio_oe ? mdio_o : sta_bit;
  assign rf_rdata = mem[rf_addr];

  always_ff @(posedge mdc or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < 32; i++) mem[i] <= 16'(i * 257);
    end else if (rf_we) mem[rf_addr] <= rf_wdata;

  mdio_slave u_dut (
    .mdc(mdc), .rst_n(rst_n), .phy_addr(phy_addr), .pre_sup_en(pre_sup_en),
    .mdio_i(mdio_i), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .rf_addr(rf_addr),
    .rf_rdata(rf_rdata), .rf_we(rf_we), .rf_wdata(rf_wdata));

  // {is_read, phy, reg, data_or_expected, addressed}
  localparam logic [27:0] VEC [9] = '{
    {1'b0, 5'd9, 5'd3,  16'hA5C3, 1'b1},
    {1'b0, 5'd4, 5'd17, 16'h1234, 1'b0},
    {1'b1, 5'd9, 5'd3,  16'hA5C3, 1'b1},
    {1'b1, 5'd9, 5'd17, 16'h1111, 1'b1},
    {1'b0, 5'd9, 5'd31, 16'h8001, 1'b1},
    {1'b1, 5'd9, 5'd31, 16'h8001, 1'b1},
    {1'b1, 5'd8, 5'd3,  16'hA5C3, 1'b0},
    {1'b0, 5'd9, 5'd0,  16'h7E5A, 1'b1},
    {1'b1, 5'd9, 5'd0,  16'h7E5A, 1'b1}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bit_io(input logic b);
    @(negedge mdc);
    obs_oe = mdio_oe;
    obs_o  = mdio_o;
    obs_we = rf_we;
    sta_bit = b;
  endtask

  task automatic frame(input int pre_n, input logic [1:0] stb, input logic [1:0] opb,
                       input logic [4:0] pa, input logic [4:0] ra, input logic [15:0] d,
                       input bit act, input string req);
    logic [13:0] hdr;
    logic [15:0] rx;
    bit quiet;
    bit rdf;
    rdf = (opb == 2'b10);
    hdr = {stb, opb, pa, ra};
    quiet = 1'b1;
    for (int i = 0; i < pre_n; i++) begin bit_io(1'b1); if (obs_oe) quiet = 1'b0; end
    for (int i = 13; i >= 0; i--) begin bit_io(hdr[i]); if (obs_oe) quiet = 1'b0; end
    chk(quiet, {req, " header undriven"}, 32'(!quiet), 0);
    if (rdf) begin
      bit_io(1'b1);
      chk(!obs_oe, {req, " R3 turnaround bit1 released"}, 32'(obs_oe), 0);
      bit_io(1'b1);
      chk(obs_oe == act && (!act || !obs_o), {req, " R3 turnaround bit2"},
          {obs_oe, obs_o}, {act, 1'b0});
      quiet = 1'b1;
      rx = '0;
      for (int i = 15; i >= 0; i--) begin
        bit_io(1'b1);
        if (!obs_oe) quiet = 1'b0;
        rx[i] = obs_oe ? obs_o : 1'b1;
        if (!act && obs_oe) quiet = 1'b0;
      end
      if (act) begin
        chk(quiet, {req, " R4 data driven"}, 32'(quiet), 1);
        chk(rx == d, {req, " R4 read word"}, rx, d);
      end else begin
        chk(rx == 16'hFFFF, {req, " R6 no drive"}, rx, 16'hFFFF);
      end
      bit_io(1'b1);
      chk(!obs_oe, {req, " R4 idle released"}, 32'(obs_oe), 0);
    end else begin
      bit_io(1'b1); bit_io(1'b0);
      for (int i = 15; i >= 0; i--) begin
        bit_io(d[i]);
        if (obs_oe || obs_we) quiet = 1'b0;
      end
      chk(quiet, {req, " R5 no early strobe"}, 32'(!quiet), 0);
      bit_io(1'b1);
      chk(obs_we == act, {req, " R5 strobe"}, 32'(obs_we), 32'(act));
      if (act) chk(rf_addr == ra && rf_wdata == d, {req, " R5 addr/data"},
                   {11'd0, rf_addr, rf_wdata}, {11'd0, ra, d});
    end
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge mdc);
    chk(!mdio_oe && !rf_we, "R8 reset outputs", {mdio_oe, rf_we}, 0);
    rst_n = 1'b1;

    for (int v = 0; v < 9; v++)
      frame(32, 2'b01, VEC[v][27] ? 2'b10 : 2'b01, VEC[v][26:22], VEC[v][21:17],
            VEC[v][16:1], VEC[v][0], $sformatf("vec%0d R6", v));

    bit_io(1'b0);
    frame(31, 2'b01, 2'b01, 5'd9, 5'd5, 16'hBEEF, 1'b0, "R1 short preamble");
    frame(32, 2'b01, 2'b10, 5'd9, 5'd5, 16'h0505, 1'b1, "R1 readback");

    frame(32, 2'b01, 2'b11, 5'd9, 5'd6, 16'h0000, 1'b0, "R7 opcode 11");
    frame(32, 2'b01, 2'b00, 5'd9, 5'd6, 16'h0000, 1'b0, "R7 opcode 00");
    frame(32, 2'b00, 2'b01, 5'd9, 5'd6, 16'h0000, 1'b0, "R7 start 00");
    frame(32, 2'b01, 2'b10, 5'd9, 5'd6, 16'h0606, 1'b1, "R7 readback");

    frame(0, 2'b01, 2'b10, 5'd9, 5'd3, 16'hA5C3, 1'b0, "R9 no preamble");
    frame(0, 2'b01, 2'b01, 5'd9, 5'd7, 16'h1357, 1'b0, "R9 write no preamble");
    frame(32, 2'b01, 2'b10, 5'd9, 5'd7, 16'h0707, 1'b1, "R9 readback");

    pre_sup_en = 1'b1;
    frame(0, 2'b01, 2'b10, 5'd9, 5'd3, 16'hA5C3, 1'b1, "R2 read suppressed");
    frame(0, 2'b01, 2'b01, 5'd9, 5'd9, 16'h4242, 1'b1, "R2 write suppressed");
    frame(0, 2'b01, 2'b10, 5'd9, 5'd9, 16'h4242, 1'b1, "R2 readback");
    pre_sup_en = 1'b0;

    repeat (4) bit_io(1'b1);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule